// File: doc/BRIEF.md
# Block-Based Pattern Sequencer with Two-Pattern Changeover

This block reads a word-wide pattern memory and streams the words to a data-generator output. It has two modes. In sequence mode it plays up to four memory blocks in ascending order. One contiguous range of those blocks can be repeated, either a set number of times or forever. In two-pattern mode the memory address space is cut into a lower half and an upper half. Each half holds one pattern of a programmable number of blocks, and the active pattern repeats without a break. A side input (`aux`) selects the active half. A switch of half is held back until the last word of the running pattern has been read.

The `aux` input works in one of four ways, chosen by `cfg_aux_mode`:
- It can start a run.
- Its pulses can flip the half.
- Its level can pick the half.
- While high in sequence mode, it can force the output word to zero.

A run can also be started by the `start` command. The control is one state machine with three states:
- `ST_IDLE`: waiting for a start.
- `ST_SEQ`: sequence playback.
- `ST_ALT`: two-pattern playback.

It has five named transitions:
- *launch-seq*: `ST_IDLE`→`ST_SEQ` on a start with `cfg_alt`=0.
- *launch-alt*: `ST_IDLE`→`ST_ALT` on a start with `cfg_alt`=1.
- *loop-back*: `ST_SEQ`→`ST_SEQ` when the last block of the loop range ends and passes remain; playback jumps to the first loop block.
- *finish*: `ST_SEQ`→`ST_IDLE` when block `cfg_seq_last` ends and no pass remains.
- *wrap*: `ST_ALT`→`ST_ALT` when a pattern ends; any pending change of half is applied here.

Top module: `pattern_seq`

## Requirements
- R1: After reset, `mem_rd_en`, `dout_valid` and `dout` are all 0.
- R2: A start seen in `ST_IDLE` makes the next cycle read address 0 with `mem_rd_en`=1. Each word read appears on `dout` with `dout_valid`=1 one cycle after its read.
- R3: In sequence mode, blocks 0 to `cfg_seq_last` play in ascending order, and each block's words are read at ascending addresses (block index × words per block + word). One cycle after the last word is output, `dout_valid` falls to 0.
- R4: Blocks `cfg_loop_first` to `cfg_loop_last` play `cfg_loop_cnt` times in total before playback goes on to the next block.
- R5: A `cfg_loop_cnt` of 0 repeats the loop range without end.
- R6: With `cfg_aux_mode`=0, a rising edge on `aux` in `ST_IDLE` starts a run exactly as `start` does.
- R7: In two-pattern mode (`cfg_alt`=1), the pattern is `cfg_alt_blocks` blocks long. It is read from base address 0 (half 0) or from half the memory size (half 1). Playback begins in half 0 and repeats with no gaps.
- R8: The active half changes only between the last word of one pattern and the first word of the next.
- R9: With `cfg_aux_mode`=2, the `aux` level sampled on the last word of a pattern selects the half of the next pattern.
- R10: With `cfg_aux_mode`=1 and `cfg_oneshot`=0, any rising edges during a pattern flip the half for the next pattern, and the new half stays active.
- R11: With `cfg_aux_mode`=1 and `cfg_oneshot`=1, the pattern that follows a pulse plays from half 1 once. Later patterns play from half 0 until another pulse comes.
- R12: With `cfg_aux_mode`=3 and `cfg_alt`=0, each word read while `aux` is high is output as zero, and `dout_valid` stays 1.
- R13: With `cfg_aux_mode`=3 and `cfg_alt`=1, `aux` neither blanks data nor changes the half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command pulse |
| aux | input | 1 | Side input: start, flip, select or blank |
| cfg_alt | input | 1 | 1 = two-pattern mode, 0 = sequence mode |
| cfg_aux_mode | input | 2 | 0 start, 1 pulse flip, 2 level select, 3 blank |
| cfg_oneshot | input | 1 | Pulse mode: 1 = play the other half once |
| cfg_seq_last | input | 2 | Index of the last block in sequence mode |
| cfg_loop_first | input | 2 | First block of the loop range |
| cfg_loop_last | input | 2 | Last block of the loop range |
| cfg_loop_cnt | input | LCW | Passes over the loop range; 0 = endless |
| cfg_alt_blocks | input | ALW | Pattern length in blocks for two-pattern mode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_data | input | W | Memory read data, valid in the cycle of the address |
| dout | output | W | Output data word |
| dout_valid | output | 1 | `dout` holds a pattern word |

## Verification
The bench builds the block with 8-bit words and 32-bit blocks, which gives four words per block, and with a 32-word memory, which gives two halves of four blocks each. Because of this, every address a pattern reads can be read directly from the data it returns. Each loop pass lasts only a handful of cycles. A two-pattern run crosses several half changes within about thirty words. Under these settings, all loop ranges, endless looping, every `aux` mode and both changeover methods can be covered in a short run.

// File: rtl/psq_pkg.sv
package psq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_ALT  = 2'd2
    } psq_state_e;

    typedef enum logic [1:0] {
        AUX_START = 2'd0,
        AUX_PULSE = 2'd1,
        AUX_LEVEL = 2'd2,
        AUX_BLANK = 2'd3
    } psq_aux_e;
endpackage

// File: rtl/psq_aux_edge.sv
module psq_aux_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= aux_in;
    end

    assign rise = aux_in & ~prev_q;
endmodule

// File: rtl/psq_loop_ctr.sv
module psq_loop_ctr #(
    parameter int LCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LCW-1:0] cnt,
    input  logic           take,
    output logic           again
);
    logic [LCW-1:0] left_q;
    logic           inf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            inf_q  <= 1'b0;
        end else if (load) begin
            inf_q  <= (cnt == '0);
            left_q <= cnt - 1'b1;
        end else if (take && !inf_q) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign again = inf_q | (left_q != '0);

    // R4: a finite loop is never taken with no passes left
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !inf_q) |-> (left_q != '0));
endmodule

// File: rtl/psq_out_stage.sv
module psq_out_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic         blank,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] dout,
    output logic         dout_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= rd_en;
            dout       <= (rd_en && !blank) ? rdata : '0;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> dout_valid);
    a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !dout_valid);
    a_r12_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && blank) |=> (dout == '0));
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
    import psq_pkg::*;
#(
    parameter int W          = 64,
    parameter int BLOCK_BITS = 512,
    parameter int AW         = 12,
    parameter int LCW        = 16,
    localparam int WPB  = BLOCK_BITS / W,
    localparam int PW   = $clog2(WPB),
    localparam int HALF = 2 ** (AW - 1),
    localparam int HBLK = HALF / WPB,
    localparam int ALW  = $clog2(HBLK) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           aux,
    input  logic           cfg_alt,
    input  logic [1:0]     cfg_aux_mode,
    input  logic           cfg_oneshot,
    input  logic [1:0]     cfg_seq_last,
    input  logic [1:0]     cfg_loop_first,
    input  logic [1:0]     cfg_loop_last,
    input  logic [LCW-1:0] cfg_loop_cnt,
    input  logic [ALW-1:0] cfg_alt_blocks,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_addr,
    input  logic [W-1:0]   mem_data,
    output logic [W-1:0]   dout,
    output logic           dout_valid
);
    psq_state_e    st_q, st_d;
    psq_aux_e      amode;
    logic [AW-2:0] pos_q, pos_d;
    logic [1:0]    blk_q, blk_d;
    logic          half_q, half_d;
    logic          pend_q, pend_d;
    logic          aux_rise, go, blk_end, pat_end, blank;
    logic          loop_load, loop_take, loop_again;
    logic [AW-1:0] pat_words, pat_last;

    assign amode     = psq_aux_e'(cfg_aux_mode);
    assign go        = start | ((amode == AUX_START) & aux_rise);
    assign blk_end   = (pos_q == (AW-1)'(WPB - 1));
    assign pat_words = AW'(cfg_alt_blocks) << PW;
    assign pat_last  = pat_words - 1'b1;
    assign pat_end   = ({1'b0, pos_q} == pat_last);
    assign blank     = (amode == AUX_BLANK) & ~cfg_alt & aux;

    psq_aux_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .aux_in (aux),
        .rise   (aux_rise)
    );

    psq_loop_ctr #(.LCW(LCW)) i_loop (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (loop_load),
        .cnt   (cfg_loop_cnt),
        .take  (loop_take),
        .again (loop_again)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pos_q  <= '0;
            blk_q  <= '0;
            half_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pos_q  <= pos_d;
            blk_q  <= blk_d;
            half_q <= half_d;
            pend_q <= pend_d;
        end
    end

    // next state
    always_comb begin
        st_d      = st_q;
        pos_d     = pos_q;
        blk_d     = blk_q;
        half_d    = half_q;
        pend_d    = pend_q | ((amode == AUX_PULSE) & aux_rise);
        loop_load = 1'b0;
        loop_take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_d      = cfg_alt ? ST_ALT : ST_SEQ;
                    pos_d     = '0;
                    blk_d     = '0;
                    half_d    = 1'b0;
                    pend_d    = 1'b0;
                    loop_load = 1'b1;
                end
            end
            ST_SEQ: begin
                if (blk_end) begin
                    pos_d = '0;
                    if (blk_q == cfg_loop_last && loop_again) begin
                        blk_d     = cfg_loop_first;
                        loop_take = 1'b1;
                    end else if (blk_q == cfg_seq_last) begin
                        st_d = ST_IDLE;
                    end else begin
                        blk_d = blk_q + 1'b1;
                    end
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            ST_ALT: begin
                if (pat_end) begin
                    pos_d = '0;
                    unique case (amode)
                        AUX_LEVEL: half_d = aux;
                        AUX_PULSE: begin
                            half_d = cfg_oneshot ? pend_q : (half_q ^ pend_q);
                            pend_d = aux_rise;
                        end
                        default: half_d = half_q;
                    endcase
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        unique case (st_q)
            ST_SEQ: begin
                mem_rd_en = 1'b1;
                mem_addr  = AW'({blk_q, pos_q[PW-1:0]});
            end
            ST_ALT: begin
                mem_rd_en = 1'b1;
                mem_addr  = {half_q, pos_q};
            end
            default: begin
                mem_rd_en = 1'b0;
                mem_addr  = '0;
            end
        endcase
    end

    psq_out_stage #(.W(W)) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (mem_rd_en),
        .blank      (blank),
        .rdata      (mem_data),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    a_r8_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALT && !pat_end) |=> $stable(half_q));
    a_r3_blk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEQ) |-> (blk_q <= cfg_seq_last));
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEQ && !blk_end) |=> (mem_addr == $past(mem_addr) + 1'b1));
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALT && !pat_end) |=> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: tb/test_pattern_seq.sv
module test_pattern_seq;
    localparam int W = 8, BB = 32, AW = 5, LCW = 8, ALW = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, aux = 1'b0;
    logic cfg_alt = 1'b0, cfg_oneshot = 1'b0;
    logic [1:0] cfg_aux_mode = 2'd1, cfg_seq_last = '0, cfg_loop_first = '0, cfg_loop_last = '0;
    logic [LCW-1:0] cfg_loop_cnt = '0;
    logic [ALW-1:0] cfg_alt_blocks = 3'd2;
    logic mem_rd_en, dout_valid;
    logic [AW-1:0] mem_addr;
    logic [W-1:0] mem_data, dout;
    int total = 0, bad = 0;

    always #5 clk = ~clk;
    assign mem_data = 8'h80 | {3'b000, mem_addr};

    pattern_seq #(.W(W), .BLOCK_BITS(BB), .AW(AW), .LCW(LCW)) i_pattern_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .aux(aux), .cfg_alt(cfg_alt),
        .cfg_aux_mode(cfg_aux_mode), .cfg_oneshot(cfg_oneshot), .cfg_seq_last(cfg_seq_last),
        .cfg_loop_first(cfg_loop_first), .cfg_loop_last(cfg_loop_last),
        .cfg_loop_cnt(cfg_loop_cnt), .cfg_alt_blocks(cfg_alt_blocks),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_data(mem_data),
        .dout(dout), .dout_valid(dout_valid));

    // {seq_last, loop_first, loop_last, loop_cnt, blocks (0 = endless), block list 2 bits each}
    localparam logic [51:0] SEQ_TAB [6] = '{
        {2'd3, 2'd0, 2'd0, 8'd1, 6'd4, 32'h000000E4},
        {2'd3, 2'd1, 2'd2, 8'd2, 6'd6, 32'h00000E64},
        {2'd2, 2'd0, 2'd2, 8'd3, 6'd9, 32'h00024924},
        {2'd0, 2'd0, 2'd0, 8'd1, 6'd1, 32'h00000000},
        {2'd3, 2'd3, 2'd3, 8'd4, 6'd7, 32'h00003FE4},
        {2'd1, 2'd0, 2'd1, 8'd0, 6'd0, 32'h00044444}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // 4 patterns of 8 words; aux driven at word 2 of each pattern
    task automatic alt_run(input string req, input bit pulse, input logic [3:0] vec,
                           input logic [3:0] exp_half);
        for (int n = 0; n < 32; n++) begin
            @(negedge clk);
            if (pulse) aux = 1'b0;
            chk(req, {23'd0, dout_valid, dout},
                {23'd0, 1'b1, 8'h80 | 8'((exp_half[n/8] ? 16 : 0) + n % 8)});
            if (n % 8 == 2) begin
                if (pulse) aux = vec[n/8];
                else       aux = vec[n/8];
            end
        end
        aux = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R0 watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 reset", {29'd0, mem_rd_en, dout_valid, |dout}, 32'd0);

        // table walk: sequence mode, R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            logic [31:0] lst;
            int nb, nw;
            string tag;
            cfg_alt = 1'b0; cfg_aux_mode = 2'd1;
            cfg_seq_last   = SEQ_TAB[v][51:50];
            cfg_loop_first = SEQ_TAB[v][49:48];
            cfg_loop_last  = SEQ_TAB[v][47:46];
            cfg_loop_cnt   = SEQ_TAB[v][45:38];
            nb  = int'(SEQ_TAB[v][37:32]);
            lst = SEQ_TAB[v][31:0];
            tag = (v == 5) ? "R5 endless" : ((v == 0 || v == 3) ? "R3 order" : "R4 loop");
            nw  = (nb == 0) ? 40 : nb * 4;
            do_reset();
            kick();
            if (v == 0) chk("R2 first read", {26'd0, mem_rd_en, mem_addr, dout_valid},
                            {26'd0, 1'b1, 5'd0, 1'b0});
            for (int n = 0; n < nw; n++) begin
                @(negedge clk);
                chk(tag, {23'd0, dout_valid, dout},
                    {23'd0, 1'b1, 8'h80 | 8'(int'(lst[2*(n/4) +: 2]) * 4 + n % 4)});
            end
            @(negedge clk);
            chk({tag, " end"}, {31'd0, dout_valid}, (nb == 0) ? 32'd1 : 32'd0);
        end

        // R6: aux rising edge starts a run
        cfg_aux_mode = 2'd0; cfg_seq_last = 2'd0; cfg_loop_cnt = 8'd1;
        cfg_loop_first = 2'd0; cfg_loop_last = 2'd0;
        do_reset();
        @(negedge clk); aux = 1'b1;
        @(negedge clk); aux = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk("R6 aux start", {23'd0, dout_valid, dout}, {23'd0, 1'b1, 8'h80 | 8'(n)});
        end
        @(negedge clk);
        chk("R6 aux start end", {31'd0, dout_valid}, 32'd0);

        // R12: blanking in sequence mode
        cfg_aux_mode = 2'd3; cfg_seq_last = 2'd3;
        do_reset();
        kick();
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            chk("R12 blank", {23'd0, dout_valid, dout},
                {23'd0, 1'b1, (n >= 6 && n <= 8) ? 8'h00 : (8'h80 | 8'(n))});
            if (n == 5) aux = 1'b1;
            if (n == 8) aux = 1'b0;
        end

        // two-pattern mode: R7 R8 R9 R10 R11 R13
        cfg_alt = 1'b1; cfg_alt_blocks = 3'd2;
        cfg_aux_mode = 2'd2; cfg_oneshot = 1'b0;
        do_reset(); kick();
        alt_run("R9 R8 level select", 1'b0, 4'b0011, 4'b0110);

        cfg_aux_mode = 2'd1; cfg_oneshot = 1'b0;
        do_reset(); kick();
        alt_run("R10 R7 pulse flip", 1'b1, 4'b0101, 4'b0110);

        cfg_oneshot = 1'b1;
        do_reset(); kick();
        alt_run("R11 one-shot", 1'b1, 4'b0001, 4'b0010);

        cfg_aux_mode = 2'd3; cfg_oneshot = 1'b0;
        do_reset();
        aux = 1'b1;
        kick();
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            chk("R13 blank ignored", {23'd0, dout_valid, dout},
                {23'd0, 1'b1, 8'h80 | 8'(n % 8)});
        end
        aux = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule